// File: doc/BRIEF.md
# Edge-Aligned PWM Channel

This block generates one pulse-width-modulated output from a free-running up counter. The counter advances by one on each counter-tick strobe and returns to zero on the tick after it reaches a programmable modulus, so one PWM period is modulus plus one ticks long. A duty value sets how many ticks of each period the output spends at its active level. The active stretch starts when the counter wraps to zero and ends when the counter reaches the duty value.

A polarity input selects the active level. With polarity 0 the pulse is high-true: the wrap drives the output high and the duty match drives it low. With polarity 1 the pulse is low-true: the wrap drives it low and the match drives it high. A duty of zero keeps the output inactive for the whole period. A duty above the modulus keeps it active for the whole period. The count is exported so that other channels can share it. The asynchronous reset is released synchronously inside the block.

Top module: `pwm_edge_channel`

## Requirements
- R1: While reset is applied and until the synchronized release, count_o is 0 and pwm_o sits at the inactive level, which equals polarity_i.
- R2: On a cycle with tick_i high and count_o below modulus_i, count_o rises by exactly one at the next clock edge.
- R3: On a cycle with tick_i high and count_o at or above modulus_i, count_o becomes 0 at the next clock edge. A steady modulus therefore gives a period of modulus_i + 1 ticks.
- R4: On a cycle with tick_i low, count_o and the registered active state are unchanged at the next clock edge.
- R5: With polarity_i = 0, after each tick pwm_o is 1 exactly when the new count is below the duty_i value sampled on that tick, and 0 otherwise.
- R6: With polarity_i = 1, after each tick pwm_o is 0 exactly when the new count is below the duty_i value sampled on that tick, and 1 otherwise.
- R7: A duty_i of 0 keeps pwm_o at the inactive level (equal to polarity_i) on every tick of the period.
- R8: A duty_i greater than modulus_i keeps pwm_o at the active level (the inverse of polarity_i) on every tick of the period.
- R9: A change of polarity_i inverts pwm_o in the same cycle, without waiting for a tick.
- R10: With modulus_i = 0, count_o stays at 0 on every tick, so the period is one tick long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Counter-tick strobe; the count and the output advance only when it is high |
| modulus_i | input | CNT_W (16) | Terminal count; the count wraps after reaching it |
| duty_i | input | CNT_W (16) | Number of active ticks per period |
| polarity_i | input | 1 | 0 selects high-true pulses, 1 selects low-true pulses |
| count_o | output | CNT_W (16) | Current counter value |
| pwm_o | output | 1 | PWM output |

## Verification
The bench aims at the duty extremes. A design that compares with less-or-equal instead of less-than would emit a one-tick glitch at 0% duty, or lose a tick at the top of the range. Zero modulus and a modulus lowered below the current count both test the wrap: a design that wraps only on equality would run past the new limit for tens of thousands of ticks. Idle cycles between sparse ticks show whether the output moves without a tick. Polarity flips between ticks show whether the inversion was applied before the register, which would delay it until the next tick.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic {
    POL_HIGH_TRUE = 1'b0,
    POL_LOW_TRUE  = 1'b1
  } pwm_pol_e;

  // Drive level for a given active state under a given polarity.
  function automatic logic pwm_level(input logic active, input pwm_pol_e pol);
    return (pol == POL_LOW_TRUE) ? ~active : active;
  endfunction

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] modulus_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_next_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             at_top;

  always_comb begin
    at_top  = (count_q >= modulus_i);
    count_d = at_top ? '0 : count_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (tick_i) count_q <= count_d;
  end

  assign count_o      = count_q;
  assign count_next_o = count_d;

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_q < modulus_i) |=> count_q == $past(count_q) + CNT_W'(1));

  // R3
  count_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_q >= modulus_i) |=> count_q == '0);

  // R4
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_q));

endmodule

// File: rtl/pwm_match.sv
module pwm_match #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count_next_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             active_next_o
);

  // Active from the wrap to zero until the count reaches the duty value.
  always_comb begin
    active_next_o = (count_next_i < duty_i);
  end

endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage
  import pwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic active_next_i,
  input  logic polarity_i,
  output logic pwm_o
);

  logic active_q;
  logic active_d;

  always_comb begin
    active_d = tick_i ? active_next_i : active_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_d;
  end

  always_comb begin
    pwm_o = pwm_level(active_q, pwm_pol_e'(polarity_i));
  end

  // R4
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(active_q));

  // R9
  polarity_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_o ^ polarity_i) == active_q);

endmodule

// File: rtl/pwm_edge_channel.sv
module pwm_edge_channel #(
  parameter int CNT_W      = 16,
  parameter int RST_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] modulus_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             polarity_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pwm_o
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] count_next;
  logic             active_next;

  pwm_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  pwm_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .tick_i       (tick_i),
    .modulus_i    (modulus_i),
    .count_o      (count_o),
    .count_next_o (count_next)
  );

  pwm_match #(.CNT_W(CNT_W)) i_match (
    .count_next_i  (count_next),
    .duty_i        (duty_i),
    .active_next_o (active_next)
  );

  pwm_outstage i_outstage (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .tick_i        (tick_i),
    .active_next_i (active_next),
    .polarity_i    (polarity_i),
    .pwm_o         (pwm_o)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_sync_n |-> (count_o == '0 && pwm_o == polarity_i));

  // R7
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (tick_i && duty_i == '0) |=> pwm_o == polarity_i);

  // R8
  full_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (tick_i && duty_i > modulus_i) |=> pwm_o != polarity_i);

  // R10
  zero_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (tick_i && modulus_i == '0) |=> count_o == '0);

endmodule

// File: tb/test_pwm_edge_channel.sv
module test_pwm_edge_channel;

  localparam int W = 16;

  logic         clk;
  logic         rst_n;
  logic         tick;
  logic [W-1:0] mod;
  logic [W-1:0] duty;
  logic         pol;
  logic [W-1:0] count_o;
  logic         pwm_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [W-1:0] m_cnt = '0;
  logic         m_act = 1'b0;

  pwm_edge_channel i_pwm_edge_channel (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .modulus_i  (mod),
    .duty_i     (duty),
    .polarity_i (pol),
    .count_o    (count_o),
    .pwm_o      (pwm_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // One clock cycle: drive at the falling edge, update model at the rising edge, check after it.
  task automatic cyc(input logic t, input logic [W-1:0] m, input logic [W-1:0] d, input logic p);
    string ctag;
    string ptag;
    @(negedge clk);
    tick = t; mod = m; duty = d; pol = p;
    @(posedge clk);
    if (t) begin
      if (m == '0)        ctag = "R10";
      else if (m_cnt >= m) ctag = "R3";
      else                ctag = "R2";
      m_cnt = (m_cnt >= m) ? '0 : m_cnt + 16'd1;
      m_act = (m_cnt < d);
      if (d == '0)    ptag = "R7";
      else if (d > m) ptag = "R8";
      else if (p)     ptag = "R6";
      else            ptag = "R5";
    end else begin
      ctag = "R4";
      ptag = "R4";
    end
    #2;
    check(count_o == m_cnt, ctag, int'(count_o), int'(m_cnt));
    check(pwm_o == (m_act ^ p), ptag, int'(pwm_o), int'(m_act ^ p));
  endtask

  initial begin
    #5ms;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick = 1'b0; mod = 16'd5; duty = 16'd2; pol = 1'b0;
    #22;
    // R1: reset state under both polarities
    check(count_o == '0, "R1", int'(count_o), 0);
    check(pwm_o == 1'b0, "R1", int'(pwm_o), 0);
    pol = 1'b1; #1;
    check(pwm_o == 1'b1, "R1", int'(pwm_o), 1);
    pol = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    // ticks ignored until the synchronized release
    repeat (3) cyc(1'b0, 16'd5, 16'd2, 1'b0);

    // R10: zero modulus, period of one tick, duty 1 is full on
    repeat (4) cyc(1'b1, 16'd0, 16'd1, 1'b0);
    // R7: zero duty over several periods, both polarities
    repeat (12) cyc(1'b1, 16'd5, 16'd0, 1'b0);
    repeat (12) cyc(1'b1, 16'd5, 16'd0, 1'b1);
    // R8: duty beyond modulus, both polarities
    repeat (12) cyc(1'b1, 16'd5, 16'd6, 1'b1);
    repeat (12) cyc(1'b1, 16'd5, 16'd6, 1'b0);
    // R5/R6: duty equal to modulus and a middle value, with idle gaps (R4)
    repeat (14) cyc(1'b1, 16'd5, 16'd5, 1'b0);
    repeat (10) begin
      cyc(1'b1, 16'd5, 16'd3, 1'b1);
      cyc(1'b0, 16'd5, 16'd0, 1'b1);
    end
    // R9: polarity flip between ticks changes the output at once
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      tick = 1'b0;
      pol = ~pol;
      #1;
      check(pwm_o == (m_act ^ pol), "R9", int'(pwm_o), int'(m_act ^ pol));
    end
    // R3: modulus lowered below the running count wraps on the next tick
    repeat (12) cyc(1'b1, 16'd20, 16'd7, 1'b0);
    repeat (3) cyc(1'b1, 16'd4, 16'd2, 1'b0);

    // Random phase
    begin
      logic [W-1:0] rm;
      logic [W-1:0] rd;
      logic         rp;
      rm = 16'd7; rd = 16'd3; rp = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        if (($urandom % 40) == 0) begin
          rm = 16'($urandom % 20);
          rd = 16'($urandom % (int'(rm) + 3));
        end
        if (($urandom % 60) == 0) rp = ~rp;
        cyc(($urandom % 10) < 7, rm, rd, rp);
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule